// File: doc/BRIEF.md
# Reconfiguration Register Write Sequencer

This block is a small memory-mapped bus master that applies one setting to a transceiver reconfiguration controller. It works on the controller's indirect register set. A user request names a logical channel, a feature offset and a new value. The block first waits for the controller to report idle on its control/status word. It then writes the channel, offset and value into their registers and sets the control word's write-trigger bit. Finally it polls the status word again until the controller is no longer busy, and pulses done.

Each bus access holds its address, strobe and write data while the slave stalls. Each read stays outstanding until the slave returns data. A polling phase that runs too long ends the request with a sticky error flag, and the bus is always left in a clean state when that happens.

Top module: `reg_write_seq`

## Requirements
- R1: After a synchronous active-high reset the read and write strobes, busy, done and error are all low and the block waits for a request.
- R2: Before any write, the block reads the control/status word (word address 2) again and again. It issues its first write only after a read returns with bit 8 (the controller's busy flag) at zero.
- R3: The four writes come in a fixed order: the channel number zero-extended to address 0, then the offset zero-extended to address 3, then the data to address 4, then a word to address 2 in which only bit 0 (the write trigger) is set.
- R4: After the trigger write, the block polls address 2 again until bit 8 reads zero. It then raises done for exactly one cycle. The number of reads in each phase equals the number of busy replies in that phase plus one.
- R5: While waitrequest is high, the address, write data and both strobes stay unchanged. Read and write are never high together. A read counts as complete only when readdatavalid arrives.
- R6: The channel, offset and data are captured on a start pulse while the block is idle. busy is high from the following cycle until the request ends. A start pulse that arrives while busy is ignored and does not change what is written.
- R7: A polling phase can run for TIMEOUT_CYC cycles or more. If a read then returns with bit 8 still set, the block returns to idle, raises error, gives no done pulse and issues no further writes.
- R8: error stays high through later requests and is cleared only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse |
| req_chan | input | 10 | Logical channel number |
| req_offs | input | 16 | Feature offset address |
| req_data | input | 32 | New setting value |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Sticky timeout flag |
| avm_address | output | 4 | Word address to the controller |
| avm_read | output | 1 | Read strobe |
| avm_write | output | 1 | Write strobe |
| avm_writedata | output | 32 | Write data |
| avm_readdata | input | 32 | Read data |
| avm_readdatavalid | input | 1 | Read data valid |
| avm_waitrequest | input | 1 | Slave stall |

## Verification
The bench model stalls at random and returns reads after a random delay. It also reports busy for a chosen number of polls before and after the trigger. A design that skipped or shortened a polling phase would show the wrong read count. A design that dropped a strobe during a stall would lose or repeat a write in the logged order. A second start pulse is injected in the middle of a request to catch a design that reloads its captured fields. A controller that stays busy forever, before and after the trigger, checks that the abort gives no done pulse and makes no stray writes. It also checks that error stays set until reset.

// File: rtl/reg_write_seq.sv
module reg_write_seq #(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32,
  parameter int CHAN_W      = 10,
  parameter int OFFS_W      = 16,
  parameter int BUSY_BIT    = 8,
  parameter int TRIG_BIT    = 0,
  parameter logic [ADDR_W-1:0] CSR_ADDR  = 4'd2,
  parameter logic [ADDR_W-1:0] CHAN_ADDR = 4'd0,
  parameter logic [ADDR_W-1:0] OFFS_ADDR = 4'd3,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 4'd4,
  parameter int TIMEOUT_CYC = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CHAN_W-1:0] req_chan,
  input  logic [OFFS_W-1:0] req_offs,
  input  logic [DATA_W-1:0] req_data,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [ADDR_W-1:0] avm_address,
  output logic              avm_read,
  output logic              avm_write,
  output logic [DATA_W-1:0] avm_writedata,
  input  logic [DATA_W-1:0] avm_readdata,
  input  logic              avm_readdatavalid,
  input  logic              avm_waitrequest
);

  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TW-1:0] TLIM = TW'(TIMEOUT_CYC - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_PRE_RD, S_PRE_WT, S_WR_CH, S_WR_OF, S_WR_DT, S_WR_GO, S_POST_RD, S_POST_WT
  } state_t;

  state_t            state;
  logic [CHAN_W-1:0] chan_q;
  logic [OFFS_W-1:0] offs_q;
  logic [DATA_W-1:0] data_q;
  logic [TW-1:0]     tcnt;

  logic polling, waiting, rsp_busy, rsp_clear, give_up;

  assign busy      = (state != S_IDLE);
  assign avm_read  = (state == S_PRE_RD) || (state == S_POST_RD);
  assign avm_write = (state == S_WR_CH) || (state == S_WR_OF) ||
                     (state == S_WR_DT) || (state == S_WR_GO);
  assign waiting   = (state == S_PRE_WT) || (state == S_POST_WT);
  assign polling   = avm_read || waiting;
  assign rsp_busy  = waiting && avm_readdatavalid && avm_readdata[BUSY_BIT];
  assign rsp_clear = waiting && avm_readdatavalid && !avm_readdata[BUSY_BIT];
  assign give_up   = rsp_busy && (tcnt >= TLIM);

  always_comb begin
    avm_address   = CSR_ADDR;
    avm_writedata = '0;
    case (state)
      S_WR_CH: begin avm_address = CHAN_ADDR; avm_writedata = DATA_W'(chan_q); end
      S_WR_OF: begin avm_address = OFFS_ADDR; avm_writedata = DATA_W'(offs_q); end
      S_WR_DT: begin avm_address = DATA_ADDR; avm_writedata = data_q; end
      S_WR_GO: avm_writedata = DATA_W'(1) << TRIG_BIT;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      done   <= 1'b0;
      error  <= 1'b0;
      tcnt   <= '0;
      chan_q <= '0;
      offs_q <= '0;
      data_q <= '0;
    end else begin
      done <= 1'b0;
      if (!polling)        tcnt <= '0;
      else if (tcnt < TLIM) tcnt <= tcnt + 1'b1;
      case (state)
        S_IDLE: if (start) begin
          chan_q <= req_chan;
          offs_q <= req_offs;
          data_q <= req_data;
          state  <= S_PRE_RD;
        end
        S_PRE_RD:  if (!avm_waitrequest) state <= S_PRE_WT;
        S_PRE_WT:  if (rsp_clear) state <= S_WR_CH; else if (rsp_busy) state <= S_PRE_RD;
        S_WR_CH:   if (!avm_waitrequest) state <= S_WR_OF;
        S_WR_OF:   if (!avm_waitrequest) state <= S_WR_DT;
        S_WR_DT:   if (!avm_waitrequest) state <= S_WR_GO;
        S_WR_GO:   if (!avm_waitrequest) state <= S_POST_RD;
        S_POST_RD: if (!avm_waitrequest) state <= S_POST_WT;
        S_POST_WT: if (rsp_clear) begin
          state <= S_IDLE;
          done  <= 1'b1;
        end else if (rsp_busy) state <= S_POST_RD;
        default: state <= S_IDLE;
      endcase
      if (give_up) begin
        state <= S_IDLE;
        error <= 1'b1;
      end
    end
  end

  AST_RW_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(avm_read && avm_write)); // R5

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    (avm_read || avm_write) && avm_waitrequest |=>
      $stable(avm_address) && $stable(avm_writedata) && $stable(avm_read) && $stable(avm_write)); // R5

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R4

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && !avm_read && !avm_write); // R4

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    error |=> error); // R8

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    busy && start |=> $stable(chan_q) && $stable(offs_q) && $stable(data_q)); // R6

  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (rst)
    $rose(error) |-> !busy && !done); // R7

endmodule

// File: tb/sim_reg_write_seq.sv
module sim_reg_write_seq;
  localparam int TMO = 64;

  logic        clk = 0, rst = 1, start = 0;
  logic [9:0]  req_chan = 0;
  logic [15:0] req_offs = 0;
  logic [31:0] req_data = 0;
  logic        busy, done, error;
  logic [3:0]  avm_address;
  logic        avm_read, avm_write;
  logic [31:0] avm_writedata, avm_readdata;
  logic        avm_readdatavalid, avm_waitrequest;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  reg_write_seq #(.TIMEOUT_CYC(TMO)) u0 (
    .clk(clk), .rst(rst), .start(start), .req_chan(req_chan), .req_offs(req_offs),
    .req_data(req_data), .busy(busy), .done(done), .error(error),
    .avm_address(avm_address), .avm_read(avm_read), .avm_write(avm_write),
    .avm_writedata(avm_writedata), .avm_readdata(avm_readdata),
    .avm_readdatavalid(avm_readdatavalid), .avm_waitrequest(avm_waitrequest));

  // controller model
  logic        ws = 0;
  int          busy_left = 0, post_busy = 0, rdv_cnt = 0;
  int          nwr = 0, nrd = 0, nrd_pre = 0, ndone = 0;
  logic [3:0]  log_a [0:15];
  logic [31:0] log_d [0:15];

  assign avm_waitrequest = ws && (avm_read || avm_write);

  always @(posedge clk) begin
    ws <= ($urandom % 4) == 0;
    avm_readdatavalid <= 1'b0;
    if (rdv_cnt != 0) rdv_cnt <= rdv_cnt - 1;
    if (rdv_cnt == 1) begin
      avm_readdatavalid <= 1'b1;
      avm_readdata <= (busy_left > 0) ? 32'h100 : 32'h0;
      if (busy_left > 0) busy_left <= busy_left - 1;
    end
    if (avm_read && !avm_waitrequest) begin
      rdv_cnt <= 1 + ($urandom % 3);
      nrd <= nrd + 1;
    end
    if (avm_write && !avm_waitrequest) begin
      if (nwr < 16) begin log_a[nwr] <= avm_address; log_d[nwr] <= avm_writedata; end
      if (nwr == 0) nrd_pre <= nrd;
      nwr <= nwr + 1;
      if (avm_address == 4'd2 && avm_writedata[0]) busy_left <= post_busy;
    end
    if (done) ndone <= ndone + 1;
  end

  initial avm_readdata = 0;
  initial avm_readdatavalid = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_addr(input int i);
    case (i) 0: return 4'd0; 1: return 4'd3; 2: return 4'd4; default: return 4'd2; endcase
  endfunction

  function automatic logic [31:0] exp_data(input int i, input logic [9:0] c,
                                           input logic [15:0] o, input logic [31:0] d);
    case (i) 0: return {22'd0, c}; 1: return {16'd0, o}; 2: return d; default: return 32'd1; endcase
  endfunction

  task automatic do_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
  endtask

  task automatic pulse_start(input logic [9:0] c, input logic [15:0] o, input logic [31:0] d);
    req_chan = c; req_offs = o; req_data = d; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic run_op(input logic [9:0] c, input logic [15:0] o, input logic [31:0] d,
                        input int preb, input int postb, input bit inject);
    int d0, k;
    @(negedge clk);
    nwr = 0; nrd = 0; nrd_pre = 0;
    busy_left = preb; post_busy = postb;
    d0 = ndone;
    pulse_start(c, o, d);
    chk(busy === 1'b1, "R6 busy after start", busy, 1);
    if (inject) begin
      repeat (3) @(negedge clk);
      pulse_start(~c, ~o, ~d);
    end
    k = 0;
    while (!done && k < 3000) begin @(negedge clk); k++; end
    chk(done === 1'b1, "R4 done seen", done, 1);
    chk(busy === 1'b0, "R6 busy low at done", busy, 0);
    @(negedge clk);
    chk(done === 1'b0, "R4 done one cycle", done, 0);
    chk(ndone == d0 + 1, "R4 single done pulse", ndone, d0 + 1);
    chk(nwr == 4, "R3 write count", nwr, 4);
    chk(nrd_pre == preb + 1, "R2 reads before first write", nrd_pre, preb + 1);
    chk(nrd == preb + postb + 2, "R4 total polls", nrd, preb + postb + 2);
    for (int i = 0; i < 4; i++) begin
      chk(log_a[i] == exp_addr(i), inject ? "R6 addr under ignored start" : "R3 write addr",
          log_a[i], exp_addr(i));
      chk(log_d[i] == exp_data(i, c, o, d), inject ? "R6 data under ignored start" : "R3 write data",
          log_d[i], exp_data(i, c, o, d));
    end
  endtask

  initial begin
    void'($urandom(32'h1357));
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int d0;
    do_reset();
    // R1 reset state
    chk(!avm_read && !avm_write, "R1 strobes idle", {avm_read, avm_write}, 0);
    chk(!busy && !done && !error, "R1 flags low", {busy, done, error}, 0);

    run_op(10'h001, 16'h0005, 32'hCAFE_0001, 0, 0, 0);
    run_op(10'h3FF, 16'hFFFF, 32'hFFFF_FFFF, 3, 2, 0);           // R3 extremes
    run_op(10'h000, 16'h0000, 32'h0000_0000, 5, 6, 1);           // R6 ignored start
    for (int n = 0; n < 20; n++)                                 // R5 random stalls
      run_op(10'($urandom), 16'($urandom), $urandom, $urandom % 5, $urandom % 5, ($urandom % 4) == 0);

    // R7 timeout before trigger
    @(negedge clk);
    nwr = 0; busy_left = 100000; post_busy = 0; d0 = ndone;
    pulse_start(10'h2A, 16'h14, 32'h1234_5678);
    for (int k = 0; k < 400 && !error; k++) @(negedge clk);
    chk(error === 1'b1, "R7 error on pre timeout", error, 1);
    chk(busy === 1'b0, "R7 idle after abort", busy, 0);
    repeat (10) @(negedge clk);
    chk(nwr == 0, "R7 no writes after pre abort", nwr, 0);
    chk(ndone == d0, "R7 no done on abort", ndone, d0);

    // R8 error persists across a good request
    repeat (5) @(negedge clk);
    run_op(10'h055, 16'h00AA, 32'h5A5A_A5A5, 1, 1, 0);
    chk(error === 1'b1, "R8 error sticky", error, 1);
    do_reset();
    chk(error === 1'b0, "R8 reset clears error", error, 0);

    // R7 timeout after trigger
    @(negedge clk);
    nwr = 0; busy_left = 0; post_busy = 100000; d0 = ndone;
    pulse_start(10'h3C3, 16'hBEEF, 32'h0BAD_F00D);
    for (int k = 0; k < 400 && !error; k++) @(negedge clk);
    chk(error === 1'b1, "R7 error on post timeout", error, 1);
    repeat (10) @(negedge clk);
    chk(nwr == 4, "R7 no extra writes after post abort", nwr, 4);
    chk(ndone == d0, "R7 no done on post abort", ndone, d0);
    chk(!avm_read && !avm_write, "R7 bus quiet after abort", {avm_read, avm_write}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule